// File: doc/BRIEF.md
# Streaming AES Round-Key Generator

This block turns an AES cipher key into its expanded round-key schedule, one 32-bit word per accepted transfer, without ever holding the whole schedule. It keeps a sliding window of the most recent key words, at most eight of them, and derives each new word from the newest and the oldest entry of that window. A single datapath serves 128-, 192- and 256-bit keys. Word rotation, byte substitution, the round constant and the extra mid-group substitution used with 256-bit keys are all computed on the fly. The substitution bytes come from field inversion plus the affine map, not from a stored table.

A run begins with a one-cycle `start` pulse that samples `keylen`. The key words are then taken in over a valid/ready input, first word first, with bits [31:24] holding the first byte of each word. Every word, key words included, leaves through a valid/ready output together with its schedule index. The input is ready only while key words are still expected and the output slot is empty or being drained. The output holds its word and index steady for as long as `out_valid` is high and `out_ready` is low. After the final word is taken, `done` pulses for one cycle and the block returns to idle.

Top module: `aks_keygen`

## Requirements
- R1: `keylen` 2'b00 selects a 128-bit key and emits 44 words. 2'b01 selects 192 bits and emits 52 words. 2'b10 and 2'b11 both select 256 bits and emit 60 words. `out_index` counts 0, 1, 2, … up to the last word, with no gaps.
- R2: The first Nk output words (Nk = 4, 6 or 8) are the key words, unchanged and in the order they were accepted.
- R3: For an index i ≥ Nk that is not covered by R4 or R5, the word equals word[i−Nk] XOR word[i−1].
- R4: When i is a multiple of Nk, the word equals word[i−Nk] XOR SubWord(RotWord(word[i−1])) XOR {rc, 24'h0}. RotWord moves the top byte to the bottom. rc starts at 8'h01 and is doubled in GF(2^8), with reduction by 8'h1B, for each later group.
- R5: For 256-bit keys, when i mod 8 equals 4, the word equals word[i−8] XOR SubWord(word[i−1]), with no rotation and no round constant.
- R6: While `out_valid` is high and `out_ready` is low, `out_word` and `out_index` stay unchanged. A word is consumed only in a cycle where both are high.
- R7: `key_ready` is low while the block is idle. Exactly Nk key words are accepted per run, and any further words offered are refused.
- R8: `done` is high for exactly one cycle, the cycle after the last word is consumed. `out_valid` stays low from then until a new run starts.
- R9: A `start` pulse that arrives while a run is in progress is ignored. The run continues with its original key length.
- R10: After reset, `out_valid`, `key_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run when idle |
| keylen | input | 2 | Key length code, sampled with start |
| key_valid | input | 1 | Key word offered |
| key_ready | output | 1 | Key word can be taken this cycle |
| key_word | input | 32 | Key word, first byte in bits [31:24] |
| out_valid | output | 1 | Schedule word available |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | 32 | Schedule word |
| out_index | output | 6 | Index of the schedule word |
| done | output | 1 | Pulses once after the last word is consumed |

## Verification
The checker assumes a few things about the block's neighbours:
- `start` is pulsed only after reset.
- The consumer samples `out_word` only on a handshake.
- After `done`, no new word appears before the index counter of the checker has been cleared.

The bench keeps to these assumptions. It pulses `start` while the block is idle, except for one deliberate pulse in the middle of a run. It also drives all inputs half a cycle away from the active edge, so every handshake seen by the checker is the one the bench intended. The consumer's ready pattern and the key source's gap pattern are fixed and deterministic, so stalls land both on key words and on generated words.

// File: rtl/aks_pkg.sv
package aks_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int LANES     = WORD_W / BYTE_W;
  localparam int MAX_NK    = 8;
  localparam int MAX_WORDS = 60;
  localparam int IDX_W     = $clog2(MAX_WORDS + 1);
  localparam int POS_W     = $clog2(MAX_NK);
  localparam int NK_W      = POS_W + 1;

  typedef enum logic [1:0] {KS_128 = 2'd0, KS_192 = 2'd1, KS_256 = 2'd2} keysz_e;

  function automatic keysz_e decode_ks(input logic [1:0] code);
    case (code)
      2'd0:    return KS_128;
      2'd1:    return KS_192;
      default: return KS_256;
    endcase
  endfunction

  function automatic logic [NK_W-1:0] nk_of(input keysz_e ks);
    case (ks)
      KS_128:  return NK_W'(4);
      KS_192:  return NK_W'(6);
      default: return NK_W'(8);
    endcase
  endfunction

  // four words per round key, Nr + 1 round keys, Nr = Nk + 6
  function automatic logic [IDX_W-1:0] total_of(input keysz_e ks);
    return IDX_W'(4 * (int'(nk_of(ks)) + 7));
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254, then the affine map
  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] base;
    logic [7:0] ex;
    r    = 8'h01;
    base = x;
    ex   = 8'd254;
    for (int k = 0; k < 8; k++) begin
      if (ex[k]) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]}
             ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aks_sbox.sv
module aks_sbox
  import aks_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  assign dout = sbox_fwd(din);
endmodule

// File: rtl/aks_subword.sv
module aks_subword
  import aks_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic [NLANES*BYTE_W-1:0] din,
  output logic [NLANES*BYTE_W-1:0] dout
);
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    aks_sbox u_sbox (
      .din  (din[g*BYTE_W +: BYTE_W]),
      .dout (dout[g*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/aks_window.sv
module aks_window
  import aks_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int DEPTH = MAX_NK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] din,
  input  keysz_e       ks,
  output logic [W-1:0] newest,
  output logic [W-1:0] oldest
);
  localparam int SEL_W = $clog2(DEPTH);

  logic [W-1:0]     win_q [DEPTH];
  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) win_q[k] <= '0;
    end else if (shift) begin
      win_q[0] <= din;
      for (int k = 1; k < DEPTH; k++) win_q[k] <= win_q[k-1];
    end
  end

  assign sel    = SEL_W'(nk_of(ks) - NK_W'(1));
  assign newest = win_q[0];
  assign oldest = win_q[sel];
endmodule

// File: rtl/aks_seq.sv
module aks_seq
  import aks_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       keylen,
  input  logic             key_valid,
  input  logic             slot_free,
  input  logic             last_fire,
  output logic             key_ready,
  output logic             key_take,
  output logic             gen_take,
  output keysz_e           ks,
  output logic [POS_W-1:0] pos,
  output logic [7:0]       rcon,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] total,
  output logic             done
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_GEN} st_e;

  st_e              st_q;
  keysz_e           ks_q;
  logic [IDX_W-1:0] idx_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;
  logic [7:0]       rcon_q;
  logic             done_q;
  logic [NK_W-1:0]  nk;

  assign nk        = nk_of(ks_q);
  assign total     = total_of(ks_q);
  assign key_ready = (st_q == ST_LOAD) && slot_free;
  assign key_take  = key_ready && key_valid;
  assign gen_take  = (st_q == ST_GEN) && slot_free && (idx_q != total);
  assign pos_nxt   = ({1'b0, pos_q} == nk - NK_W'(1)) ? '0 : pos_q + POS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ks_q   <= KS_128;
      idx_q  <= '0;
      pos_q  <= '0;
      rcon_q <= 8'h01;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            ks_q   <= decode_ks(keylen);
            idx_q  <= '0;
            pos_q  <= '0;
            rcon_q <= 8'h01;
            st_q   <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (key_take) begin
            idx_q <= idx_q + IDX_W'(1);
            pos_q <= pos_nxt;
            if (idx_q == IDX_W'(nk - NK_W'(1))) st_q <= ST_GEN;
          end
        end
        ST_GEN: begin
          if (gen_take) begin
            idx_q <= idx_q + IDX_W'(1);
            pos_q <= pos_nxt;
            if (pos_q == '0) rcon_q <= xtime(rcon_q);
          end
          if (last_fire) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ks   = ks_q;
  assign pos  = pos_q;
  assign rcon = rcon_q;
  assign idx  = idx_q;
  assign done = done_q;
endmodule

// File: rtl/aks_keygen.sv
module aks_keygen
  import aks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        keylen,
  input  logic              key_valid,
  output logic              key_ready,
  input  logic [WORD_W-1:0] key_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [IDX_W-1:0]  out_index,
  output logic              done
);
  localparam int MID_POS = MAX_NK / 2;

  logic              slot_free;
  logic              last_fire;
  logic              key_take;
  logic              gen_take;
  logic              push;
  keysz_e            ks;
  logic [POS_W-1:0]  pos;
  logic [7:0]        rcon;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  total;
  logic [WORD_W-1:0] prev_w;
  logic [WORD_W-1:0] back_w;
  logic [WORD_W-1:0] sub_in;
  logic [WORD_W-1:0] sub_out;
  logic [WORD_W-1:0] mix_w;
  logic [WORD_W-1:0] gen_w;
  logic [WORD_W-1:0] push_w;
  logic              ov_q;
  logic [WORD_W-1:0] ow_q;
  logic [IDX_W-1:0]  oi_q;

  assign slot_free = !ov_q || out_ready;
  assign last_fire = ov_q && out_ready && (oi_q == total - IDX_W'(1));
  assign push      = key_take || gen_take;

  aks_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .keylen    (keylen),
    .key_valid (key_valid),
    .slot_free (slot_free),
    .last_fire (last_fire),
    .key_ready (key_ready),
    .key_take  (key_take),
    .gen_take  (gen_take),
    .ks        (ks),
    .pos       (pos),
    .rcon      (rcon),
    .idx       (idx),
    .total     (total),
    .done      (done)
  );

  aks_window u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (push),
    .din    (push_w),
    .ks     (ks),
    .newest (prev_w),
    .oldest (back_w)
  );

  // one substitution unit shared by the group-start and mid-group steps
  assign sub_in = (pos == '0) ? {prev_w[WORD_W-BYTE_W-1:0], prev_w[WORD_W-1 -: BYTE_W]}
                              : prev_w;

  aks_subword u_sub (
    .din  (sub_in),
    .dout (sub_out)
  );

  always_comb begin
    if (pos == '0)
      mix_w = sub_out ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};
    else if (ks == KS_256 && pos == POS_W'(MID_POS))
      mix_w = sub_out;
    else
      mix_w = prev_w;
  end

  assign gen_w  = back_w ^ mix_w;
  assign push_w = key_take ? key_word : gen_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ow_q <= '0;
      oi_q <= '0;
    end else if (push) begin
      ov_q <= 1'b1;
      ow_q <= push_w;
      oi_q <= idx;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;
  assign out_index = oi_q;
endmodule

// File: rtl/aks_keygen_chk.sv
module aks_keygen_chk
  import aks_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              key_valid,
  input logic              key_ready,
  input logic [WORD_W-1:0] key_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic [IDX_W-1:0]  out_index,
  input logic              done
);
  logic [IDX_W-1:0] exp_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      exp_idx <= '0;
    else if (done)                   exp_idx <= '0;
    else if (out_valid && out_ready) exp_idx <= exp_idx + IDX_W'(1);
  end

  p_seq_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_index == exp_idx);

  p_idx_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_index < IDX_W'(MAX_WORDS));

  p_key_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_ready |=> out_valid && out_word == $past(key_word));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_index));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

bind aks_keygen aks_keygen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_valid (key_valid),
  .key_ready (key_ready),
  .key_word  (key_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_index (out_index),
  .done      (done)
);

// File: tb/aks_keygen_test.sv
module aks_keygen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRUN = 4;
  localparam int NANCH = 6;

  localparam logic [1:0] RUN_CODE [NRUN] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam int RUN_NK  [NRUN] = '{4, 6, 8, 8};
  localparam int RUN_TOT [NRUN] = '{44, 52, 60, 60};
  localparam int RUN_RDY [NRUN] = '{0, 1, 2, 1};
  localparam int RUN_GAP [NRUN] = '{0, 1, 1, 0};
  localparam logic [255:0] RUN_KEY [NRUN] = '{
    256'h2b7e1516_28aed2a6_abf71588_09cf4f3c_00000000_00000000_00000000_00000000,
    256'h8e73b0f7_da0e6452_c810f32b_809079e5_62f8ead2_522c6b7b_00000000_00000000,
    256'h603deb10_15ca71be_2b73aef0_857d7781_1f352c07_3b6108d7_2d9810a3_0914dff4,
    256'h0};
  // {run, index, expected word}: published expansion values
  localparam logic [39:0] ANCH [NANCH] = '{
    {2'd0, 6'd4,  32'ha0fafe17}, {2'd0, 6'd43, 32'hb6630ca6},
    {2'd1, 6'd6,  32'hfe0c91f7}, {2'd1, 6'd51, 32'h01002202},
    {2'd2, 6'd59, 32'h706c631e}, {2'd3, 6'd8,  32'h62636363}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  keylen = 2'd0;
  logic        key_valid = 1'b0;
  logic        key_ready;
  logic [31:0] key_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic [5:0]  out_index;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [31:0] got_w [NRUN][60];
  logic [5:0]  got_i [NRUN][60];
  logic [31:0] exp_w [60];

  always #(CLK_PERIOD/2) clk = ~clk;

  aks_keygen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .keylen(keylen),
    .key_valid(key_valid), .key_ready(key_ready), .key_word(key_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_index(out_index), .done(done));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] s = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p ^= s;
      s = s[7] ? ({s[6:0], 1'b0} ^ 8'h1b) : {s[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sub(input logic [7:0] x);
    logic [7:0] inv = 8'h00;
    logic [7:0] c = 8'h63;
    logic [7:0] o;
    for (int y = 1; y < 256; y++)
      if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int k = 0; k < 8; k++)
      o[k] = inv[k] ^ inv[(k+4)%8] ^ inv[(k+5)%8] ^ inv[(k+6)%8] ^ inv[(k+7)%8] ^ c[k];
    return o;
  endfunction

  function automatic logic [31:0] m_subw(input logic [31:0] w);
    return {m_sub(w[31:24]), m_sub(w[23:16]), m_sub(w[15:8]), m_sub(w[7:0])};
  endfunction

  task automatic model(input int r);
    int nk = RUN_NK[r];
    logic [31:0] t;
    logic [7:0] rc;
    for (int i = 0; i < RUN_TOT[r]; i++) begin
      if (i < nk) exp_w[i] = RUN_KEY[r][255-32*i -: 32];
      else begin
        t = exp_w[i-1];
        if (i % nk == 0) begin
          rc = 8'h01;
          for (int g = 1; g < i / nk; g++) rc = m_mul(rc, 8'h02);
          t = m_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        end else if (nk == 8 && i % 8 == 4) t = m_subw(t);
        exp_w[i] = exp_w[i-nk] ^ t;
      end
    end
  endtask

  task automatic run_one(input int r);
    int cyc = 0;
    int kacc = 0;
    int ngot = 0;
    int dcnt = 0;
    int nk = RUN_NK[r];
    string tag;
    @(negedge clk);
    keylen = RUN_CODE[r];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc < 3000 && dcnt == 0) begin
      case (RUN_RDY[r])
        0:       out_ready = 1'b1;
        1:       out_ready = (cyc % 3 != 1);
        default: out_ready = ((cyc / 2) % 3 != 0);
      endcase
      key_valid = (RUN_GAP[r] == 0) ? 1'b1 : (cyc % 4 != 2);
      key_word  = (kacc < nk) ? RUN_KEY[r][255-32*kacc -: 32] : 32'hdeadbeef;
      start     = (r == 1 && cyc == 15); // R9: pulse during a run
      keylen    = start ? 2'd0 : RUN_CODE[r];
      #1;
      if (done) dcnt++;
      if (key_valid && key_ready) kacc++;
      if (out_valid && out_ready) begin
        if (ngot < 60) begin
          got_w[r][ngot] = out_word;
          got_i[r][ngot] = out_index;
        end
        ngot++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    key_valid = 1'b0;
    out_ready = 1'b1;
    chk(dcnt == 1, "R8", "done seen", 64'(dcnt), 64'd1);
    chk(ngot == RUN_TOT[r], "R1", "word count", 64'(ngot), 64'(RUN_TOT[r]));
    chk(kacc == nk, "R7", "key words accepted", 64'(kacc), 64'(nk));
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!done && !out_valid, "R8", "quiet after done", {done, out_valid}, 64'd0);
      @(negedge clk);
    end
    model(r);
    for (int i = 0; i < RUN_TOT[r] && i < ngot; i++) begin
      chk(got_i[r][i] == 6'(i), "R1", "index", 64'(got_i[r][i]), 64'(i));
      if (i < nk) tag = "R2";
      else if (i % nk == 0) tag = "R4";
      else if (nk == 8 && i % 8 == 4) tag = "R5";
      else tag = "R3";
      chk(got_w[r][i] === exp_w[i], tag, $sformatf("run %0d word %0d", r, i),
          64'(got_w[r][i]), 64'(exp_w[i]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !key_ready && !done, "R10", "reset outputs",
        {out_valid, key_ready, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    key_valid = 1'b1;
    key_word = 32'h12345678;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(!key_ready && !out_valid, "R7", "idle refuses keys",
          {key_ready, out_valid}, 64'd0);
      @(negedge clk);
    end
    key_valid = 1'b0;
    for (int r = 0; r < NRUN; r++) run_one(r);
    for (int a = 0; a < NANCH; a++) begin
      chk(got_w[ANCH[a][39:38]][ANCH[a][37:32]] == ANCH[a][31:0], "R4",
          $sformatf("published word run %0d idx %0d", ANCH[a][39:38], ANCH[a][37:32]),
          64'(got_w[ANCH[a][39:38]][ANCH[a][37:32]]), 64'(ANCH[a][31:0]));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule